// File: doc/BRIEF.md
# Audio Sample-Rate Window Classifier

The classifier works out which standard audio sample rate is arriving. It takes a free-running 216 MHz reference clock and an audio clock that runs at 128 times the sample rate. It counts reference cycles across eight periods of the audio clock. It then compares that count with seven programmable windows, each with a low and a high bound, and reports the first window that contains the count. If no window contains the count, it reports that instead.

The audio clock is asynchronous to the reference, so it passes through a two-flop synchroniser. Only its rising edges are used. Measurements run back to back: the edge that closes one interval also opens the next. If the audio clock stops, the counter saturates and the block reports that no rate matched. It then waits idle until the next rising edge.

The seven windows are written one entry at a time through a single write port. On reset they load bounds that the block computes from the reference frequency. Entries 0 to 6 are the defaults for 32, 44.1, 48, 88.2, 96, 176.4 and 192 kHz. Each default is a centre count with a tolerance either side. The centre is (8 × 216000000) / (f × 128), using integer division. The tolerance is 9 for rates up to 48 kHz, 6 for rates up to 96 kHz, and 2 above that.

Top module: `fs_window_classifier`

## Requirements
- R1: While reset is held and after it is released, `match_valid`, `no_match` and `match_idx` are 0. No result appears until the audio clock has produced at least nine rising edges.
- R2: After reset, entry i has the bounds centre−tol to centre+tol. The defaults are [412,430], [297,315], [272,290], [147,159], [134,146], [74,78] and [68,72] for entries 0 to 6.
- R3: The measured count is the number of reference cycles from one synchronised rising edge of the audio clock to the eighth rising edge after it. That closing edge starts the next measurement with no gap.
- R4: A count N matches entry i when low ≤ N ≤ high. Both bounds are inclusive, so low−1 and high+1 do not match.
- R5: When several entries contain the count, `match_idx` reports the lowest index among them.
- R6: When no entry contains the count, the result is reported with `no_match`=1 and `match_idx`=0.
- R7: If no closing edge arrives, the count saturates at 4095. The block then reports exactly one result with `no_match`=1 and reports nothing more until a new rising edge opens a fresh measurement.
- R8: A write with `wr_en`=1 and `wr_idx` in 0..6 replaces that entry. The low bound comes from `wr_data[11:0]` and the high bound from `wr_data[27:16]`. Bits 15:12 and 31:28 are ignored, and a write with `wr_idx` of 7 changes no entry.
- R9: `match_valid` is high for exactly one cycle per result. `match_idx` and `no_match` change only in a cycle where `match_valid` is high, and they hold their values otherwise.
- R10: `fs_clk_in` may be asynchronous to `clk`. Only its rising edges delimit intervals, and how long it stays high has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 216 MHz reference clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| fs_clk_in | input | 1 | Audio clock at 128× sample rate, asynchronous |
| wr_en | input | 1 | Window entry write strobe |
| wr_idx | input | 3 | Window entry selected for writing |
| wr_data | input | 32 | Low bound in 11:0, high bound in 27:16 |
| match_valid | output | 1 | One-cycle pulse when a result is ready |
| match_idx | output | 3 | Lowest matching entry index |
| no_match | output | 1 | Last result matched no entry |

## Verification
A corrupted interval counter or edge counter produces a wrong index or a spurious no-match at the very next result. That result is due one reference cycle after the eighth synchronised edge. A wrong default or a misplaced write field produces wrong answers just outside the bounds of the affected entry. For this reason the sweep measures every entry at low−1, low, centre, high and high+1. A broken saturation path shows up as a missing result, or a repeated one, about 4095 cycles after the audio clock stops.

// File: rtl/fs_window_classifier.sv
module fs_window_classifier #(
  parameter int unsigned REF_HZ     = 216000000,
  parameter int unsigned OVERSAMPLE = 128,
  parameter int unsigned PERIODS    = 8,
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned IDX_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fs_clk_in,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_data,
  output logic             match_valid,
  output logic [IDX_W-1:0] match_idx,
  output logic             no_match
);
  localparam int NUM_WIN = 7;
  localparam int HI_LSB  = 16;
  localparam int EC_W    = $clog2(PERIODS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [EC_W-1:0]  EC_LAST = EC_W'(PERIODS - 1);

  function automatic longint rate_of(int i);
    case (i)
      0: return 32000;
      1: return 44100;
      2: return 48000;
      3: return 88200;
      4: return 96000;
      5: return 176400;
      default: return 192000;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] def_bound(int i, bit upper);
    longint f, c, t;
    f = rate_of(i);
    c = (longint'(PERIODS) * longint'(REF_HZ)) / (f * longint'(OVERSAMPLE));
    t = (f > 96000) ? 2 : (f > 48000) ? 6 : 9;
    return upper ? CNT_W'(c + t) : CNT_W'(c - t);
  endfunction

  logic [2:0]       fs_q;
  logic             fs_rise;
  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic [EC_W-1:0]  ecnt;
  logic [CNT_W-1:0] win_lo [NUM_WIN];
  logic [CNT_W-1:0] win_hi [NUM_WIN];
  logic [NUM_WIN-1:0] hit;
  logic             hit_any;
  logic [IDX_W-1:0] hit_idx;
  logic             wr_unused;

  assign wr_unused = ^{wr_data[31:HI_LSB+CNT_W], wr_data[HI_LSB-1:CNT_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) fs_q <= '0;
    else        fs_q <= {fs_q[1:0], fs_clk_in};
  end
  assign fs_rise = fs_q[1] & ~fs_q[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        win_lo[i] <= def_bound(i, 1'b0);
        win_hi[i] <= def_bound(i, 1'b1);
      end
    end else if (wr_en && int'(wr_idx) < NUM_WIN) begin
      win_lo[wr_idx] <= wr_data[CNT_W-1:0];
      win_hi[wr_idx] <= wr_data[HI_LSB+CNT_W-1:HI_LSB];
    end
  end

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
    assign hit[g] = (cnt >= win_lo[g]) && (cnt <= win_hi[g]);
  end

  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit[i]) begin
        hit_any = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed       <= 1'b0;
      cnt         <= '0;
      ecnt        <= '0;
      match_valid <= 1'b0;
      match_idx   <= '0;
      no_match    <= 1'b0;
    end else begin
      match_valid <= 1'b0;
      if (fs_rise) begin
        if (!armed) begin
          armed <= 1'b1;
          cnt   <= CNT_W'(1);
          ecnt  <= '0;
        end else if (ecnt == EC_LAST) begin
          match_valid <= 1'b1;
          match_idx   <= hit_any ? hit_idx : '0;
          no_match    <= ~hit_any;
          cnt         <= CNT_W'(1);
          ecnt        <= '0;
        end else begin
          ecnt <= ecnt + 1'b1;
          if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        end
      end else if (armed) begin
        if (cnt == CNT_MAX) begin
          match_valid <= 1'b1;
          match_idx   <= '0;
          no_match    <= 1'b1;
          armed       <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fs_window_classifier_chk.sv
module fs_window_classifier_chk #(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             match_valid,
  input logic [IDX_W-1:0] match_idx,
  input logic             no_match,
  input logic             armed,
  input logic [CNT_W-1:0] cnt,
  input logic             fs_rise
);
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    match_valid |=> !match_valid); // R9
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !match_valid |-> ($stable(match_idx) && $stable(no_match))); // R9
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (match_valid && !no_match) |-> (match_idx < IDX_W'(7))); // R4
  AST_NOMATCH_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    no_match |-> (match_idx == '0)); // R6
  AST_SAT_REPORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !fs_rise && (cnt == {CNT_W{1'b1}})) |=> (match_valid && no_match && !armed)); // R7
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !match_valid) |=> !match_valid); // R7
endmodule

bind fs_window_classifier fs_window_classifier_chk #(.CNT_W(CNT_W), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .match_valid(match_valid), .match_idx(match_idx),
  .no_match(no_match), .armed(armed), .cnt(cnt), .fs_rise(fs_rise)
);

// File: tb/fs_window_classifier_tb_top.sv
module fs_window_classifier_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fs_clk_in = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        match_valid;
  logic [2:0]  match_idx;
  logic        no_match;

  fs_window_classifier dut_i (
    .clk(clk), .rst_n(rst_n), .fs_clk_in(fs_clk_in), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .match_valid(match_valid),
    .match_idx(match_idx), .no_match(no_match)
  );

  always #5 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  int got = 0;
  int got_idx = 0;
  int got_nm = 0;
  int low_spent = 0;
  bit done = 1'b0;
  int blo [7];
  int bhi [7];

  always @(negedge clk) begin
    if (match_valid) begin
      got++;
      got_idx = int'(match_idx);
      got_nm  = int'(no_match);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic prime();
    fs_clk_in = 1'b0; ticks(2);
    fs_clk_in = 1'b1; ticks(2);
    fs_clk_in = 1'b0;
    low_spent = 0;
  endtask

  task automatic measure(input int n);
    for (int k = 0; k < 8; k++) begin
      int len;
      len = n / 8 + ((k < n % 8) ? 1 : 0);
      fs_clk_in = 1'b0;
      ticks(len - 2 - ((k == 0) ? low_spent : 0));
      fs_clk_in = 1'b1;
      ticks(2);
    end
    fs_clk_in = 1'b0;
    ticks(4);
    low_spent = 4;
  endtask

  task automatic expect_result(input int n, input string req);
    int eidx;
    eidx = -1;
    got = 0;
    measure(n);
    for (int i = 6; i >= 0; i--)
      if (n >= blo[i] && n <= bhi[i]) eidx = i;
    check(got == 1, req, got, 1);
    if (eidx < 0) begin
      check(got_nm == 1, req, got_nm, 1);
      check(got_idx == 0, req, got_idx, 0);
    end else begin
      check(got_nm == 0, req, got_nm, 0);
      check(got_idx == eidx, req, got_idx, eidx);
    end
  endtask

  task automatic write_win(input int idx, input int lo, input int hi, input bit [3:0] junk);
    wr_idx  = 3'(idx);
    wr_data = {junk, 12'(hi), junk, 12'(lo)};
    wr_en   = 1'b1;
    ticks(1);
    wr_en   = 1'b0;
    if (idx < 7) begin
      blo[idx] = lo;
      bhi[idx] = hi;
    end
  endtask

  initial begin
    int rates [7];
    rates = '{32000, 44100, 48000, 88200, 96000, 176400, 192000};
    for (int i = 0; i < 7; i++) begin
      longint c;
      int t;
      c = 1728000000 / (longint'(rates[i]) * 128);
      t = (rates[i] > 96000) ? 2 : (rates[i] > 48000) ? 6 : 9;
      blo[i] = int'(c) - t;
      bhi[i] = int'(c) + t;
    end
    ticks(5);
    check(match_valid == 0 && no_match == 0 && match_idx == 0, "R1", int'(match_valid), 0);
    rst_n = 1'b1;
    ticks(20);
    check(got == 0 && no_match == 0 && match_idx == 0, "R1", got, 0);
    check(blo[0] == 412 && bhi[6] == 72, "R2", blo[0], 412);

    // R2 R3 R4 R6 R10: sweep around every default window, back to back
    prime();
    for (int i = 0; i < 7; i++) begin
      expect_result(blo[i] - 1, "R4");
      expect_result(blo[i], "R4");
      expect_result((blo[i] + bhi[i]) / 2, "R2");
      expect_result(bhi[i], "R4");
      expect_result(bhi[i] + 1, "R4");
    end
    expect_result(200, "R6");
    expect_result(1000, "R6");

    // R8: field positions, junk bits, out-of-range index
    write_win(7, 190, 210, 4'hf);
    expect_result(200, "R8");
    write_win(6, 500, 600, 4'ha);
    expect_result(550, "R8");
    expect_result(499, "R8");
    expect_result(600, "R8");

    // R5: overlap entry 3 with entry 2
    write_win(3, 270, 300, 4'h0);
    expect_result(285, "R5");
    expect_result(295, "R5");

    // R3: a long measurement close to the counter limit
    write_win(1, 4000, 4094, 4'h0);
    expect_result(4090, "R3");

    // R7: stopped audio clock
    got = 0;
    prime();
    ticks(4200);
    check(got == 1, "R7", got, 1);
    check(got_nm == 1 && got_idx == 0, "R7", got_nm, 1);
    got = 0;
    ticks(4200);
    check(got == 0, "R7", got, 0);
    prime();
    expect_result(281, "R7");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule